// File: doc/BRIEF.md
# Audio Link Reset Mode Sequencer

This block sits beside the digital front end of a serial audio codec. It watches the active-low link reset pin, the frame sync line and a per-edge indication of bit-clock activity, and decides which kind of reset the controller has asked for. A long low pulse on the reset pin is a cold reset, which clears all logic including the register file. A long SYNC pulse that ends while the bit clock is stopped is a warm reset. A release of the reset pin while the link is powered down is a resume after power removal. The last two keep register contents.

The block runs on a free-running reference clock, so it can time pulses while the bit clock is stopped. It emits a one-cycle full-logic reset for the cold case, and a one-cycle link-restart request with a kind code for every case. It also drives an enable that lets serial data output resume at the first frame start after the bit clock has settled. A parameter chooses primary or secondary behaviour. A secondary device takes the return of bit-clock activity as its warm reset and ignores the SYNC pulse.

Top module: `link_rst_seq`

## Requirements
- R1: After `sys_rst_n` is released, `logic_rst`, `link_restart` and `sdo_en` are 0 and `rst_kind` is 2'b00 (none).
- R2: If `link_rst_n` is sampled low on at least CYC_PER_US consecutive edges and then sampled high, outside the resume condition of R4, then in the following cycle `logic_rst` and `link_restart` are both 1 for exactly one cycle and `rst_kind` is 2'b01 (cold).
- R3: A low pulse on `link_rst_n` shorter than CYC_PER_US samples, outside the resume condition, produces no `logic_rst` and no `link_restart`.
- R4: When `link_rst_n` is sampled high after being low, and `link_pd`=1 with `resume_dis`=0, the block emits a one-cycle `link_restart` with `rst_kind` 2'b11 (resume) and leaves `logic_rst` at 0, whatever the pulse width.
- R5: With `resume_dis`=1, a release during link powerdown is treated like any other release. A long pulse gives a cold reset and a short pulse is ignored.
- R6: In a primary device, if `sync_in` is sampled high on at least CYC_PER_US consecutive edges and then sampled low while the bit clock is absent, `link_restart` pulses with `rst_kind` 2'b10 (warm) exactly GAP_CYC cycles after the falling sample, with `logic_rst` at 0. GAP_CYC is the ceiling of CYC_PER_US*163/1000.
- R7: A SYNC pulse shorter than CYC_PER_US samples, or one that falls while the bit clock is present, causes no restart.
- R8: The bit clock is absent after ABSENT_CYC consecutive samples with `bclk_edge` low. It is stable after STABLE_EDGES edges with no absence in between.
- R9: `sdo_en` rises in the cycle after the first rising SYNC sample taken while the bit clock is stable. It falls with any restart and when the bit clock becomes absent.
- R10: A secondary device (SECONDARY=1) emits a warm restart (2'b10) the cycle after it samples a `bclk_edge` while the clock is absent. It ignores SYNC pulses for reset.
- R11: `link_restart` and `logic_rst` are single-cycle pulses. `rst_kind` is non-zero exactly when `link_restart` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| sys_rst_n | input | 1 | Active-low reset of the sequencer's own flops |
| link_rst_n | input | 1 | Link reset pin, active low, already synchronous to clk_ref |
| sync_in | input | 1 | Frame sync line, synchronous to clk_ref |
| bclk_edge | input | 1 | High for one sample per observed bit-clock edge |
| link_pd | input | 1 | Link is in its powerdown state |
| resume_dis | input | 1 | Disables resume-after-power-removal detection |
| logic_rst | output | 1 | One-cycle full-logic reset, registers included |
| link_restart | output | 1 | One-cycle request to restart the bit clock and link |
| rst_kind | output | 2 | Kind of restart: 01 cold, 10 warm, 11 resume, 00 none |
| sdo_en | output | 1 | Serial data output enabled from this frame on |

## Verification
The checker checks several properties on every cycle:
- every cold reset comes with a restart and follows a release of the reset pin;
- a resume never clears registers;
- the kind code matches the restart pulse;
- a primary warm restart arrives exactly GAP_CYC cycles after the qualifying SYNC fall;
- the data enable rises only on a stable clock and drops with every restart.

The threshold boundaries can only be shown by the bench's scenarios, at one sample short of the limit and exactly at it. The same holds for the choice between cold and resume under the disable bit, for SYNC activity while the clock runs, and for a secondary device reacting to the clock coming back.

// File: rtl/alrs_pkg.sv
package alrs_pkg;

  typedef enum logic [1:0] {
    RK_NONE   = 2'b00,
    RK_COLD   = 2'b01,
    RK_WARM   = 2'b10,
    RK_RESUME = 2'b11
  } rst_kind_e;

  // Reference cycles covering two nominal bit-clock periods (~163 ns).
  function automatic int gap_cycles(input int cyc_per_us);
    return (cyc_per_us * 163 + 999) / 1000;
  endfunction

  function automatic int cnt_bits(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/alrs_level_timer.sv
module alrs_level_timer #(
  parameter int LIMIT = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise_evt,
  output logic fall_evt,
  output logic long_q
);
  import alrs_pkg::*;
  localparam int W = cnt_bits(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] run_q;
  logic         level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else begin
      level_q <= level;
      if (!level)        run_q <= '0;
      else if (!long_q)  run_q <= run_q + 1'b1;
    end
  end

  // long_q: the previous consecutive high samples reached LIMIT
  assign long_q   = (run_q >= LIM);
  assign rise_evt = level & ~level_q;
  assign fall_evt = ~level & level_q;
endmodule

// File: rtl/alrs_bclk_mon.sv
module alrs_bclk_mon #(
  parameter int ABSENT_CYC   = 8,
  parameter int STABLE_EDGES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_edge,
  output logic absent,
  output logic stable,
  output logic resume_evt
);
  import alrs_pkg::*;
  localparam int GW = cnt_bits(ABSENT_CYC);
  localparam int RW = cnt_bits(STABLE_EDGES);
  localparam logic [GW-1:0] GMAX = GW'(ABSENT_CYC);
  localparam logic [RW-1:0] RMAX = RW'(STABLE_EDGES);

  logic [GW-1:0] idle_q;
  logic [RW-1:0] edges_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= GMAX;
      edges_q <= '0;
    end else if (bclk_edge) begin
      idle_q <= '0;
      if (absent)              edges_q <= RW'(1);
      else if (edges_q < RMAX) edges_q <= edges_q + 1'b1;
    end else begin
      if (idle_q < GMAX) idle_q <= idle_q + 1'b1;
      if (idle_q + 1'b1 >= GMAX) edges_q <= '0;
    end
  end

  assign absent     = (idle_q >= GMAX);
  assign stable     = (edges_q >= RMAX) && !absent;
  assign resume_evt = bclk_edge & absent;
endmodule

// File: rtl/alrs_gap_timer.sv
module alrs_gap_timer #(
  parameter int GAP = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic fire
);
  import alrs_pkg::*;
  localparam int W = cnt_bits(GAP);

  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 left_q <= '0;
    else if (cancel)            left_q <= '0;
    else if (start)             left_q <= W'(GAP);
    else if (left_q != '0)      left_q <= left_q - 1'b1;
  end

  assign fire = (left_q == W'(1)) && !cancel;
endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq #(
  parameter int CYC_PER_US   = 125,
  parameter int ABSENT_CYC   = 8,
  parameter int STABLE_EDGES = 16,
  parameter bit SECONDARY    = 1'b0
) (
  input  logic       clk_ref,
  input  logic       sys_rst_n,
  input  logic       link_rst_n,
  input  logic       sync_in,
  input  logic       bclk_edge,
  input  logic       link_pd,
  input  logic       resume_dis,
  output logic       logic_rst,
  output logic       link_restart,
  output logic [1:0] rst_kind,
  output logic       sdo_en
);
  import alrs_pkg::*;
  localparam int GAP_CYC = gap_cycles(CYC_PER_US);

  // named internal events, observed by the bound checker
  logic rel_evt, rst_long, rst_rise_unused;
  logic sync_rise, sync_fall, sync_long;
  logic bclk_absent, bclk_stable, bclk_resume;
  logic warm_arm, warm_hit, cold_hit, resume_hit;
  logic restart_next;
  rst_kind_e kind_next;

  alrs_level_timer #(.LIMIT(CYC_PER_US)) u_rst_tmr (
    .clk(clk_ref), .rst_n(sys_rst_n), .level(~link_rst_n),
    .rise_evt(rst_rise_unused), .fall_evt(rel_evt), .long_q(rst_long)
  );

  alrs_level_timer #(.LIMIT(CYC_PER_US)) u_sync_tmr (
    .clk(clk_ref), .rst_n(sys_rst_n), .level(sync_in),
    .rise_evt(sync_rise), .fall_evt(sync_fall), .long_q(sync_long)
  );

  alrs_bclk_mon #(.ABSENT_CYC(ABSENT_CYC), .STABLE_EDGES(STABLE_EDGES)) u_bclk (
    .clk(clk_ref), .rst_n(sys_rst_n), .bclk_edge(bclk_edge),
    .absent(bclk_absent), .stable(bclk_stable), .resume_evt(bclk_resume)
  );

  assign resume_hit = rel_evt & link_pd & ~resume_dis;
  assign cold_hit   = rel_evt & ~(link_pd & ~resume_dis) & rst_long;

  generate
    if (SECONDARY) begin : g_secondary
      assign warm_arm = 1'b0;
      assign warm_hit = bclk_resume;
    end else begin : g_primary
      assign warm_arm = sync_fall & sync_long & bclk_absent & link_rst_n;
      alrs_gap_timer #(.GAP(GAP_CYC)) u_gap (
        .clk(clk_ref), .rst_n(sys_rst_n), .start(warm_arm),
        .cancel(cold_hit | resume_hit | ~link_rst_n), .fire(warm_hit)
      );
    end
  endgenerate

  always_comb begin
    if (cold_hit)        kind_next = RK_COLD;
    else if (resume_hit) kind_next = RK_RESUME;
    else if (warm_hit)   kind_next = RK_WARM;
    else                 kind_next = RK_NONE;
  end
  assign restart_next = (kind_next != RK_NONE);

  always_ff @(posedge clk_ref or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      logic_rst    <= 1'b0;
      link_restart <= 1'b0;
      rst_kind     <= RK_NONE;
      sdo_en       <= 1'b0;
    end else begin
      logic_rst    <= cold_hit;
      link_restart <= restart_next;
      rst_kind     <= kind_next;
      if (restart_next || bclk_absent)  sdo_en <= 1'b0;
      else if (bclk_stable && sync_rise) sdo_en <= 1'b1;
    end
  end
endmodule

// File: rtl/link_rst_seq_chk.sv
module link_rst_seq_chk #(
  parameter int GAP_CYC      = 21,
  parameter int STABLE_EDGES = 16,
  parameter bit SECONDARY    = 1'b0
) (
  input logic       clk_ref,
  input logic       sys_rst_n,
  input logic       link_rst_n,
  input logic       logic_rst,
  input logic       link_restart,
  input logic [1:0] rst_kind,
  input logic       sdo_en,
  input logic       bclk_absent,
  input logic       bclk_stable,
  input logic       warm_arm
);
  import alrs_pkg::*;

  // cycles since the last qualifying SYNC fall, saturating
  logic [15:0] since_arm;
  always_ff @(posedge clk_ref or negedge sys_rst_n) begin
    if (!sys_rst_n)                      since_arm <= '0;
    else if (warm_arm)                   since_arm <= 16'd1;
    else if (since_arm != '0 && since_arm < 16'(GAP_CYC + 2))
      since_arm <= since_arm + 16'd1;
  end

  a_r2_cold_restarts: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    logic_rst |-> (link_restart && rst_kind == RK_COLD));

  a_r2_after_release: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    logic_rst |-> ($past(link_rst_n) && !$past(link_rst_n, 2)));

  a_r4_resume_keeps_regs: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    (link_restart && rst_kind == RK_RESUME) |-> !logic_rst);

  a_r6_warm_gap: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    (!SECONDARY && link_restart && rst_kind == RK_WARM) |-> (since_arm == 16'(GAP_CYC + 1)));

  a_r8_absent_drops_stable: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    (STABLE_EDGES > 1 && bclk_absent) |=> !bclk_stable);

  a_r9_sdo_needs_stable: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    $rose(sdo_en) |-> $past(bclk_stable));

  a_r9_sdo_off_on_restart: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    link_restart |-> !sdo_en);

  a_r11_kind_matches: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    link_restart == (rst_kind != RK_NONE));

  a_r11_cold_single: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
    logic_rst |=> !logic_rst);
endmodule

bind link_rst_seq link_rst_seq_chk #(
  .GAP_CYC(GAP_CYC), .STABLE_EDGES(STABLE_EDGES), .SECONDARY(SECONDARY)
) u_chk (
  .clk_ref(clk_ref), .sys_rst_n(sys_rst_n), .link_rst_n(link_rst_n),
  .logic_rst(logic_rst), .link_restart(link_restart), .rst_kind(rst_kind),
  .sdo_en(sdo_en), .bclk_absent(bclk_absent), .bclk_stable(bclk_stable),
  .warm_arm(warm_arm)
);

// File: tb/sim_link_rst_seq.sv
`timescale 1ns/1ps
module sim_link_rst_seq;
  localparam int CYC = 125;
  localparam int GAP = 21;   // ceil(125*163/1000)
  localparam int ABS = 8;
  localparam int STB = 16;

  logic clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic link_rst_n = 1'b1, sync_in = 1'b0, link_pd = 1'b0, resume_dis = 1'b0;
  logic bclk_on = 1'b0, ph = 1'b0;
  logic bclk_edge;
  logic lr0, rs0, sd0, lr1, rs1, sd1;
  logic [1:0] k0, k1;
  int tests = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;
  always @(negedge clk) ph <= ~ph;
  assign bclk_edge = bclk_on & ph;

  link_rst_seq u0 (.clk_ref(clk), .sys_rst_n(sys_rst_n), .link_rst_n(link_rst_n),
    .sync_in(sync_in), .bclk_edge(bclk_edge), .link_pd(link_pd), .resume_dis(resume_dis),
    .logic_rst(lr0), .link_restart(rs0), .rst_kind(k0), .sdo_en(sd0));

  link_rst_seq #(.SECONDARY(1'b1)) u1 (.clk_ref(clk), .sys_rst_n(sys_rst_n),
    .link_rst_n(link_rst_n), .sync_in(sync_in), .bclk_edge(bclk_edge), .link_pd(link_pd),
    .resume_dis(resume_dis), .logic_rst(lr1), .link_restart(rs1), .rst_kind(k1), .sdo_en(sd1));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // {low samples, link_pd, resume_dis, expected kind}
  localparam logic [13:0] RST_VEC [0:7] = '{
    {10'd125, 1'b0, 1'b0, 2'd1},   // R2 exactly at threshold
    {10'd124, 1'b0, 1'b0, 2'd0},   // R3 one short
    {10'd200, 1'b0, 1'b0, 2'd1},   // R2
    {10'd10,  1'b1, 1'b0, 2'd3},   // R4 short resume
    {10'd300, 1'b1, 1'b0, 2'd3},   // R4 long resume, no clear
    {10'd300, 1'b1, 1'b1, 2'd1},   // R5 disabled -> cold
    {10'd10,  1'b1, 1'b1, 2'd0},   // R5 disabled, short ignored
    {10'd5,   1'b0, 1'b0, 2'd0}    // R3
  };

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    chk("R1 logic_rst", lr0, 0);
    chk("R1 link_restart", rs0, 0);
    chk("R1 rst_kind", k0, 0);
    chk("R1 sdo_en", sd0, 0);
    chk("R1 secondary restart", rs1, 0);

    for (int i = 0; i < 8; i++) begin
      int low; logic [1:0] ek;
      low = int'(RST_VEC[i][13:4]);
      ek  = RST_VEC[i][1:0];
      link_pd = RST_VEC[i][3];
      resume_dis = RST_VEC[i][2];
      link_rst_n = 1'b0;
      repeat (low) @(negedge clk);
      link_rst_n = 1'b1;
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5 vec%0d kind", i), k0, ek);
      chk($sformatf("R2/R4 vec%0d restart", i), rs0, (ek != 2'd0) ? 1 : 0);
      chk($sformatf("R2/R4 vec%0d logic_rst", i), lr0, (ek == 2'd1) ? 1 : 0);
      @(negedge clk);
      chk($sformatf("R11 vec%0d pulse ends", i), rs0 | lr0, 0);
      repeat (3) @(negedge clk);
    end
    link_pd = 1'b0; resume_dis = 1'b0;

    // R6: warm reset with the bit clock stopped
    sync_in = 1'b1;
    repeat (CYC) @(negedge clk);
    sync_in = 1'b0;
    cnt = 0;
    for (int i = 1; i <= GAP; i++) begin
      @(negedge clk);
      cnt += rs0;
    end
    chk("R6 no early restart", cnt, 0);
    @(negedge clk);
    chk("R6 warm restart at gap", rs0, 1);
    chk("R6 warm kind", k0, 2);
    chk("R6 registers kept", lr0, 0);
    chk("R10 secondary ignores SYNC", rs1, 0);

    // R7: short SYNC pulse with clock stopped
    repeat (4) @(negedge clk);
    sync_in = 1'b1;
    repeat (CYC - 1) @(negedge clk);
    sync_in = 1'b0;
    cnt = 0;
    for (int i = 0; i < GAP + 4; i++) begin @(negedge clk); cnt += rs0; end
    chk("R7 short SYNC ignored", cnt, 0);

    // R10: secondary sees the clock return
    bclk_on = 1'b1;
    cnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cnt += rs1;
      if (rs1) chk("R10 secondary warm kind", k1, 2);
    end
    chk("R10 secondary one restart", cnt, 1);
    chk("R10 primary no restart on clock return", rs0, 0);

    // R9: frame start before the clock is stable
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    @(negedge clk);
    chk("R9 no enable before stable", sd0, 0);
    repeat (2 * STB + 8) @(negedge clk);
    chk("R9 enable waits for frame", sd0, 0);
    sync_in = 1'b1;
    @(negedge clk);
    chk("R9 enable on frame start", sd0, 1);
    sync_in = 1'b0;

    // R7: long SYNC while the clock runs
    repeat (4) @(negedge clk);
    sync_in = 1'b1;
    repeat (CYC + 5) @(negedge clk);
    sync_in = 1'b0;
    cnt = 0;
    for (int i = 0; i < GAP + 4; i++) begin @(negedge clk); cnt += rs0; end
    chk("R7 SYNC with clock present ignored", cnt, 0);
    chk("R9 enable kept", sd0, 1);

    // R8: clock stop
    bclk_on = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 not yet absent", sd0, 1);
    repeat (ABS + 2) @(negedge clk);
    chk("R8/R9 enable dropped when absent", sd0, 0);

    finish_run();
  end
endmodule